// File: doc/BRIEF.md
# Shadowed Register Bank with Glitch-Free Fatal Error Crossing

This block holds a small bank of configuration registers, each kept as two copies: a committed copy and a shadow copy. The shadow copy is stored bit-inverted. Software updates a register with two identical writes. The first write only stages the value. The second write, if it matches, loads both copies in the same cycle. A second write that does not match raises a recoverable update error and leaves the register as it was.

In every register, a comparator checks that the committed copy equals the inverse of the shadow copy. The result goes into a flop clocked by the source clock. Only that flop's output enters a two-flop synchronizer in a separate always-on destination clock. A comparator transient while a value changes therefore never reaches the crossing and cannot be taken as a fault.

In the destination domain, each register has its own sticky bit in a fatal error code. Any set bit drives the shared fatal alert. The code stays set until the destination reset, so firmware can find the fault by polling even when the alert is not handled. A fault-injection input flips one stored bit of a chosen shadow copy, so the check path can be exercised.

Top module: `shreg_xing_top`

## Requirements
- R1: After reset every register's committed value equals RESET_VAL (default 16'h00A5). The error code is all zeros, and fatal_alert_o and upd_err_o are low.
- R2: A first write to register i only stages the data. value_o for register i is unchanged after it, and so are all other registers.
- R3: A second write to register i with data equal to the staged data commits it. value_o slice i (bits i*W +: W) shows the data from the clock edge that samples that write.
- R4: A second write whose data differs from the staged data leaves register i unchanged. After that edge, upd_err_o[i] is high for exactly one source cycle. The next write to register i is again treated as a first write.
- R5: Each register tracks its own write phase, so first and second writes to different registers may interleave.
- R6: Sequences of two-phase writes never set any error code bit and never raise fatal_alert_o.
- R7: inj_fault_i[i] high for one source cycle flips bit 0 of register i's shadow copy. The committed value is not changed. Error code bit i is set no later than the third destination clock edge after the source edge that registers the mismatch flag. No other code bit is set.
- R8: fatal_alert_o is high whenever any error code bit is set.
- R9: A set error code bit stays set after the two copies agree again. Only rst_aon_n clears it. The destination reset does not change the committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source (register) clock |
| rst_src_n | input | 1 | Active-low reset, source domain |
| clk_aon | input | 1 | Always-on destination clock |
| rst_aon_n | input | 1 | Active-low reset, destination domain |
| wr_en_i | input | 1 | Write strobe, source domain |
| wr_idx_i | input | $clog2(N_REGS) | Register selected by the write |
| wr_data_i | input | W | Write data |
| inj_fault_i | input | N_REGS | Per-register fault injection: flips shadow bit 0 |
| value_o | output | N_REGS*W | Committed values, register i at bits i*W +: W |
| upd_err_o | output | N_REGS | One-cycle recoverable update error per register |
| fatal_alert_o | output | 1 | Fatal alert request, destination domain |
| err_code_o | output | N_REGS | Sticky fatal storage-error code, one bit per register |

## Verification
The assertions assume that wr_idx_i always selects an existing register. They also assume that a fault injection never lands in the same cycle as a matching second write to the same register, because that write would rewrite the shadow copy. They further assume that a registered mismatch flag stays high for longer than two destination cycles. The stimulus drives every input at the falling source edge and picks only valid indices. It injects faults only in cycles with no write. It leaves each corruption in place for many destination cycles before repairing it, so every flag the synchronizer must see is held long enough.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic {
        PH_STAGE   = 1'b0,
        PH_CONFIRM = 1'b1
    } wr_phase_e;

endpackage

// File: rtl/shreg_cell.sv
module shreg_cell
    import shreg_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         inj_fault_i,
    output logic [W-1:0] value_o,
    output logic         upd_err_o,
    output logic         stor_err_o
);

    localparam logic [W-1:0] FLIP_MASK = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] stage;
        wr_phase_e    phase;
        logic [W-1:0] commit;
        logic [W-1:0] shadow;
        logic         upd_err;
        logic         stor_err;
    } cell_state_t;

    localparam cell_state_t CELL_RST = '{
        stage:    RESET_VAL,
        phase:    PH_STAGE,
        commit:   RESET_VAL,
        shadow:   ~RESET_VAL,
        upd_err:  1'b0,
        stor_err: 1'b0
    };

    cell_state_t s_d, s_q;
    logic        copies_differ;

    always_comb begin
        s_d           = s_q;
        s_d.upd_err   = 1'b0;
        copies_differ = (s_q.commit != ~s_q.shadow);
        // comparator result is captured here, in the source clock
        s_d.stor_err  = copies_differ;
        if (wr_en_i) begin
            if (s_q.phase == PH_STAGE) begin
                s_d.stage = wr_data_i;
                s_d.phase = PH_CONFIRM;
            end else begin
                s_d.phase = PH_STAGE;
                if (wr_data_i == s_q.stage) begin
                    s_d.commit = wr_data_i;
                    s_d.shadow = ~wr_data_i;
                end else begin
                    s_d.upd_err = 1'b1;
                end
            end
        end
        if (inj_fault_i) begin
            s_d.shadow = s_d.shadow ^ FLIP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CELL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign value_o    = s_q.commit;
    assign upd_err_o  = s_q.upd_err;
    assign stor_err_o = s_q.stor_err;

    // R4
    mismatch_keeps_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd_err |-> (s_q.commit == $past(s_q.commit)));

    // R3
    commit_needs_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.commit != $past(s_q.commit)) |->
            $past(wr_en_i && (s_q.phase == PH_CONFIRM) && (wr_data_i == s_q.stage)));

    // R6
    copies_agree_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (s_q.phase == PH_CONFIRM) && (wr_data_i == s_q.stage) && !inj_fault_i)
            |=> (s_q.commit == ~s_q.shadow));

endmodule

// File: rtl/shreg_sync2.sv
module shreg_sync2 #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d.meta   = d_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.stable;

endmodule

// File: rtl/shreg_fatal.sv
module shreg_fatal #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    output logic [N-1:0] code_o,
    output logic         alert_o
);

    typedef struct packed {
        logic [N-1:0] code;
        logic         alert;
    } fatal_state_t;

    fatal_state_t s_d, s_q;

    always_comb begin
        s_d.code  = s_q.code | hit_i;
        s_d.alert = |s_d.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o  = s_q.code;
    assign alert_o = s_q.alert;

    for (genvar i = 0; i < N; i++) begin : g_bit_chk
        // R9
        code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.code[i] |=> s_q.code[i]);
        // R7
        hit_sets_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[i] |=> (s_q.code[i] && s_q.alert));
    end

    // R8
    alert_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code != '0) |-> s_q.alert);

endmodule

// File: rtl/shreg_xing_top.sv
module shreg_xing_top
    import shreg_pkg::*;
#(
    parameter int unsigned  N_REGS    = 4,
    parameter int unsigned  W         = 16,
    parameter logic [W-1:0] RESET_VAL = 16'h00A5,
    localparam int unsigned IDXW      = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                clk_src,
    input  logic                rst_src_n,
    input  logic                clk_aon,
    input  logic                rst_aon_n,
    input  logic                wr_en_i,
    input  logic [IDXW-1:0]     wr_idx_i,
    input  logic [W-1:0]        wr_data_i,
    input  logic [N_REGS-1:0]   inj_fault_i,
    output logic [N_REGS*W-1:0] value_o,
    output logic [N_REGS-1:0]   upd_err_o,
    output logic                fatal_alert_o,
    output logic [N_REGS-1:0]   err_code_o
);

    logic [N_REGS-1:0] stor_err_src;
    logic [N_REGS-1:0] stor_err_aon;

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDXW'(i));

        shreg_cell #(
            .W         (W),
            .RESET_VAL (RESET_VAL)
        ) u_cell (
            .clk         (clk_src),
            .rst_n       (rst_src_n),
            .wr_en_i     (sel),
            .wr_data_i   (wr_data_i),
            .inj_fault_i (inj_fault_i[i]),
            .value_o     (value_o[i*W +: W]),
            .upd_err_o   (upd_err_o[i]),
            .stor_err_o  (stor_err_src[i])
        );
    end

    shreg_sync2 #(
        .N (N_REGS)
    ) u_sync (
        .clk   (clk_aon),
        .rst_n (rst_aon_n),
        .d_i   (stor_err_src),
        .q_o   (stor_err_aon)
    );

    shreg_fatal #(
        .N (N_REGS)
    ) u_fatal (
        .clk     (clk_aon),
        .rst_n   (rst_aon_n),
        .hit_i   (stor_err_aon),
        .code_o  (err_code_o),
        .alert_o (fatal_alert_o)
    );

endmodule

// File: tb/shreg_xing_top_tb_top.sv
`timescale 1ns/1ps
module shreg_xing_top_tb_top;

    localparam int unsigned N    = 4;
    localparam int unsigned W    = 16;
    localparam int unsigned IDXW = 2;
    localparam logic [W-1:0] RV  = 16'h00A5;
    localparam int NV = 8;

    localparam int           T_IDX [NV] = '{0, 1, 2, 2, 3, 0, 1, 3};
    localparam logic [W-1:0] T_D1  [NV] = '{16'h1234, 16'h5555, 16'h0000, 16'hFFFF,
                                            16'h8000, 16'hABCD, 16'h0000, 16'h7FFF};
    localparam logic [W-1:0] T_D2  [NV] = '{16'h1234, 16'h5555, 16'h0001, 16'hFFFF,
                                            16'h8000, 16'hABCE, 16'h0000, 16'h7FFF};

    logic clk_src = 1'b0, clk_aon = 1'b0;
    logic rst_src_n = 1'b0, rst_aon_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [W-1:0] wr_data = '0;
    logic [N-1:0] inj = '0;
    logic [N*W-1:0] value;
    logic [N-1:0] upd_err, code;
    logic alert;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [W-1:0] exp_val [N];

    always #4 clk_src = ~clk_src;
    initial begin
        #5;
        forever #5 clk_aon = ~clk_aon;
    end

    shreg_xing_top #(.N_REGS(N), .W(W), .RESET_VAL(RV)) dut_i (
        .clk_src(clk_src), .rst_src_n(rst_src_n),
        .clk_aon(clk_aon), .rst_aon_n(rst_aon_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .inj_fault_i(inj), .value_o(value), .upd_err_o(upd_err),
        .fatal_alert_o(alert), .err_code_o(code)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_vals(input string req);
        for (int i = 0; i < N; i++)
            chk(value[i*W +: W] == exp_val[i], req, 64'(value[i*W +: W]), 64'(exp_val[i]));
    endtask

    task automatic wr(input int idx, input logic [W-1:0] d);
        @(negedge clk_src);
        wr_en = 1'b1; wr_idx = IDXW'(idx); wr_data = d;
        @(posedge clk_src); #1;
        wr_en = 1'b0;
    endtask

    task automatic inject(input int idx);
        @(negedge clk_src);
        inj[idx] = 1'b1;
        @(posedge clk_src); #1;
        inj = '0;
        @(posedge clk_src);
        repeat (3) @(posedge clk_aon);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) exp_val[i] = RV;
        repeat (3) @(negedge clk_src);
        rst_src_n = 1'b1; rst_aon_n = 1'b1;
        @(posedge clk_src); #1;
        // R1 reset state
        chk_vals("R1");
        chk(code == '0, "R1 code", 64'(code), 0);
        chk(alert == 1'b0, "R1 alert", 64'(alert), 0);
        chk(upd_err == '0, "R1 upd_err", 64'(upd_err), 0);

        // table walk: R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            wr(T_IDX[v], T_D1[v]);
            chk_vals("R2 after first write");
            chk(upd_err == '0, "R2 upd_err", 64'(upd_err), 0);
            wr(T_IDX[v], T_D2[v]);
            if (T_D1[v] == T_D2[v]) begin
                exp_val[T_IDX[v]] = T_D1[v];
                chk(upd_err == '0, "R3 upd_err", 64'(upd_err), 0);
                chk_vals("R3 commit");
            end else begin
                chk(upd_err == (N'(1) << T_IDX[v]), "R4 upd_err", 64'(upd_err), 64'(N'(1) << T_IDX[v]));
                chk_vals("R4 unchanged");
                @(posedge clk_src); #1;
                chk(upd_err == '0, "R4 one-cycle pulse", 64'(upd_err), 0);
            end
        end

        // R5 interleaved phases
        wr(0, 16'h0F0F);
        wr(1, 16'hF0F0);
        wr(0, 16'h0F0F);
        wr(1, 16'hF0F0);
        exp_val[0] = 16'h0F0F; exp_val[1] = 16'hF0F0;
        chk_vals("R5 interleave");
        chk(upd_err == '0, "R5 upd_err", 64'(upd_err), 0);

        // R6 no storage error from normal traffic
        repeat (6) @(posedge clk_aon); #1;
        chk(code == '0, "R6 code", 64'(code), 0);
        chk(alert == 1'b0, "R6 alert", 64'(alert), 0);

        // R7 fault on register 2
        inject(2);
        chk(code == 4'b0100, "R7 code", 64'(code), 64'h4);
        chk(alert == 1'b1, "R8 alert", 64'(alert), 1);
        chk_vals("R7 commit untouched");

        // R9 sticky after repair
        wr(2, 16'h1111);
        wr(2, 16'h1111);
        exp_val[2] = 16'h1111;
        repeat (6) @(posedge clk_aon); #1;
        chk(code == 4'b0100, "R9 sticky", 64'(code), 64'h4);
        chk(alert == 1'b1, "R9 alert held", 64'(alert), 1);

        // second fault, register 0
        inject(0);
        chk(code == 4'b0101, "R7 second code", 64'(code), 64'h5);

        // repair, then destination reset clears
        wr(0, 16'h2222);
        wr(0, 16'h2222);
        exp_val[0] = 16'h2222;
        repeat (4) @(posedge clk_aon);
        @(negedge clk_aon); rst_aon_n = 1'b0;
        @(negedge clk_aon); rst_aon_n = 1'b1;
        repeat (6) @(posedge clk_aon); #1;
        chk(code == '0, "R9 aon reset clears", 64'(code), 0);
        chk(alert == 1'b0, "R9 alert cleared", 64'(alert), 0);
        chk_vals("R9 values kept");

        finish_run();
    end

endmodule